// File: doc/BRIEF.md
# Packed Lane Add/Subtract Unit with Compare Flags

This unit treats two 32-bit words as packed vectors, either two 16-bit halfwords or four 8-bit bytes, and adds or subtracts them lane by lane. Along with the 32-bit wrapped result, it produces a 4-bit flag vector. Each flag reports whether a lane's exact, unwrapped result is greater than or equal to a threshold. The threshold depends on signedness and on the direction of the operation. Downstream select logic can then use these flags to pick bytes or halfwords.

A caller presents both operands, a 4-bit operation code and a valid strobe. One clock later, the unit returns the result, the flags and an output valid. Two "exchange" forms cross the halves of the second operand. In these forms, one halfword lane adds and the other subtracts.

Top module: `simd_addsub`

## Requirements
- R1: Result, flags and `out_valid` are registered. A beat accepted with `in_valid` high at one rising edge appears at the next edge, and `out_valid` follows `in_valid` with exactly one cycle of delay.
- R2: A synchronous active-low reset clears `result`, `ge` and `out_valid` to zero.
- R3: In halfword operations, `ge[3]` and `ge[2]` both carry the upper-halfword flag, and `ge[1]` and `ge[0]` both carry the lower-halfword flag.
- R4: In byte operations, each flag belongs to one byte: `ge[0]` to bits 7:0, `ge[1]` to 15:8, `ge[2]` to 23:16 and `ge[3]` to 31:24.
- R5: In signed operations, a lane's flag is set when the exact sum or difference of the sign-extended lane values is zero or positive.
- R6: In unsigned additions, a lane's flag is the carry out of the lane: the exact sum is at least 2^16 for a halfword or 2^8 for a byte.
- R7: In unsigned subtractions, a lane's flag is set when the lane produces no borrow, that is, when the exact difference is zero or positive.
- R8: The exchange add/subtract form computes the upper lane as A[31:16]+B[15:0] and the lower lane as A[15:0]-B[31:16]. The exchange subtract/add form computes the upper lane as A[31:16]-B[15:0] and the lower lane as A[15:0]+B[31:16].
- R9: In the unsigned exchange forms, the adding lane uses the carry rule and the subtracting lane uses the no-borrow rule. The two lanes are judged independently.
- R10: Each lane's result is the low bits of its exact result, wrapping modulo the lane width with no saturation. No carry or borrow crosses a lane boundary.
- R11: Unused operation codes (6, 7, 14, 15) give a zero result and cleared flags, and `out_valid` is still asserted.
- R12: Operation codes use bit 3 for unsigned (1) or signed (0). Bits 2:0 select the operation: 0 halfword add, 1 halfword subtract, 2 exchange add/subtract, 3 exchange subtract/add, 4 byte add, 5 byte subtract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and code are valid this cycle |
| op | input | 4 | Operation code (R12) |
| a | input | 32 | First packed operand |
| b | input | 32 | Second packed operand |
| out_valid | output | 1 | Result and flags are valid |
| result | output | 32 | Lane-wise wrapped result |
| ge | output | 4 | Per-lane greater-or-equal flags |

## Verification
Every beat's result and flags are due exactly one rising edge after the beat is accepted, and `out_valid` rises in that same cycle. The driver applies a beat on a falling edge and pushes the expected item at that moment. The monitor samples on every falling edge, so each item is popped and compared half a cycle after the edge that registered it. A beat that arrives early or late, or a valid pulse with no expected item behind it, is therefore caught as a mismatch.

// File: rtl/simd_pkg.sv
// Package: shared operation codes and decoded control for the packed
// add/subtract unit. Assumes a 4-bit code with bit 3 meaning unsigned.
package simd_pkg;

    localparam int OP_W = 4;

    typedef enum logic [2:0] {
        K_ADD16 = 3'd0,
        K_SUB16 = 3'd1,
        K_XAS   = 3'd2,   // upper adds, lower subtracts, B halves crossed
        K_XSA   = 3'd3,   // upper subtracts, lower adds, B halves crossed
        K_ADD8  = 3'd4,
        K_SUB8  = 3'd5
    } kind_e;

    typedef struct packed {
        logic legal;      // code is one of the twelve operations
        logic sgn;        // signed lane interpretation
        logic byte_mode;  // four byte lanes instead of two halfwords
        logic exch;       // cross the halves of operand B
        logic sub_hi;     // upper lane(s) subtract
        logic sub_lo;     // lower lane(s) subtract
    } ctrl_t;

endpackage

// File: rtl/simd_op_decode.sv
// Module: simd_op_decode
// Turns the 4-bit operation code into lane control bits.
// Assumes: bit 3 selects unsigned; bits 2:0 pick the operation kind.
// Codes with kind 6 or 7 are reported as not legal.
module simd_op_decode
    import simd_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output ctrl_t           ctrl
);

    // Purpose: map the operation kind onto lane direction and layout.
    always_comb begin
        ctrl = '0;
        ctrl.sgn = ~op[3];
        ctrl.legal = 1'b1;
        case (op[2:0])
            K_ADD16: begin ctrl.sub_hi = 1'b0; ctrl.sub_lo = 1'b0; end
            K_SUB16: begin ctrl.sub_hi = 1'b1; ctrl.sub_lo = 1'b1; end
            K_XAS:   begin ctrl.exch = 1'b1; ctrl.sub_hi = 1'b0; ctrl.sub_lo = 1'b1; end
            K_XSA:   begin ctrl.exch = 1'b1; ctrl.sub_hi = 1'b1; ctrl.sub_lo = 1'b0; end
            K_ADD8:  begin ctrl.byte_mode = 1'b1; end
            K_SUB8:  begin ctrl.byte_mode = 1'b1; ctrl.sub_hi = 1'b1; ctrl.sub_lo = 1'b1; end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/simd_lane.sv
// Module: simd_lane
// One lane of width W: adds or subtracts two lane values. It returns the
// low W bits and a greater-or-equal flag taken from the exact result.
// Assumes: the operands are the raw lane bits, and signedness comes from sgn.
module simd_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         sub,
    input  logic         sgn,
    output logic [W-1:0] res,
    output logic         flag
);

    localparam int EXT_W = W + 2;

    logic [EXT_W-1:0] ex, ey, exact;

    // Purpose: extend both operands by two bits so the result is exact.
    always_comb begin
        ex = sgn ? {{2{x[W-1]}}, x} : {2'b00, x};
        ey = sgn ? {{2{y[W-1]}}, y} : {2'b00, y};
        exact = sub ? (ex - ey) : (ex + ey);
    end

    // Purpose: wrap the result and pick the rule for the flag.
    // Signed or subtract: flag when the exact result is not negative.
    // Unsigned add: flag is the carry out of bit W-1.
    always_comb begin
        res  = exact[W-1:0];
        flag = (sgn || sub) ? ~exact[EXT_W-1] : exact[W];
    end

endmodule

// File: rtl/simd_addsub.sv
// Module: simd_addsub (top)
// Packed lane-wise add/subtract over two halfword or four byte lanes, with
// four greater-or-equal flags. Outputs are registered one cycle after
// in_valid. Assumes DATA_W splits into four bytes; the flag vector is 4 bits.
module simd_addsub
    import simd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic [3:0]        ge
);

    localparam int N_HALF = 2;
    localparam int N_BYTE = 4;
    localparam int HALF_W = DATA_W / N_HALF;
    localparam int BYTE_W = DATA_W / N_BYTE;

    ctrl_t ctrl;

    simd_op_decode u_dec (
        .op   (op),
        .ctrl (ctrl)
    );

    logic [DATA_W-1:0] half_res, byte_res, nxt_res;
    logic [N_HALF-1:0] half_flag;
    logic [N_BYTE-1:0] byte_flag;
    logic [3:0]        nxt_ge;
    logic              hw_q;

    // Halfword lanes: operand B halves are crossed in the exchange forms.
    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        logic [HALF_W-1:0] yb;
        assign yb = ctrl.exch ? b[(N_HALF-1-h)*HALF_W +: HALF_W]
                              : b[h*HALF_W +: HALF_W];
        simd_lane #(.W(HALF_W)) u_lane (
            .x    (a[h*HALF_W +: HALF_W]),
            .y    (yb),
            .sub  ((h == N_HALF-1) ? ctrl.sub_hi : ctrl.sub_lo),
            .sgn  (ctrl.sgn),
            .res  (half_res[h*HALF_W +: HALF_W]),
            .flag (half_flag[h])
        );
    end

    // Byte lanes: all four share one direction.
    for (genvar k = 0; k < N_BYTE; k++) begin : g_byte
        simd_lane #(.W(BYTE_W)) u_lane (
            .x    (a[k*BYTE_W +: BYTE_W]),
            .y    (b[k*BYTE_W +: BYTE_W]),
            .sub  (ctrl.sub_hi),
            .sgn  (ctrl.sgn),
            .res  (byte_res[k*BYTE_W +: BYTE_W]),
            .flag (byte_flag[k])
        );
    end

    // Purpose: choose the lane layout; unused codes give zeros.
    always_comb begin
        if (!ctrl.legal) begin
            nxt_res = '0;
            nxt_ge  = '0;
        end else if (ctrl.byte_mode) begin
            nxt_res = byte_res;
            nxt_ge  = byte_flag;
        end else begin
            nxt_res = half_res;
            nxt_ge  = {{2{half_flag[1]}}, {2{half_flag[0]}}};
        end
    end

    // Purpose: register the outputs and clear them on synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            ge        <= '0;
            hw_q      <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= nxt_res;
                ge     <= nxt_ge;
                hw_q   <= ctrl.legal && !ctrl.byte_mode;
            end
        end
    end

    assert_lat_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_reset_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (result == '0 && ge == '0 && !out_valid));
    assert_ge_pairs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && hw_q) |-> (ge[3] == ge[2] && ge[1] == ge[0]));
    assert_unused_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ctrl.legal) |=> (out_valid && result == '0 && ge == '0));
    assert_usub8_equal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'hD && a == b) |=> (ge == 4'hF && result == '0));

endmodule

// File: tb/simd_addsub_bench.sv
`timescale 1ns/1ps
module simd_addsub_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [31:0] a = '0, b = '0;
    logic        out_valid;
    logic [31:0] result;
    logic [3:0]  ge;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic [3:0]  g;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;   // 250 MHz

    simd_addsub u_simd_addsub (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .a(a), .b(b), .out_valid(out_valid), .result(result), .ge(ge)
    );

    // Reference lane built from wide integers: exact value, then rules R5/R6/R7.
    function automatic void lane_ref(input int w, input bit sgn, input bit sub,
                                     input longint x, input longint y,
                                     output longint r, output bit g);
        longint ex, ey, s, m;
        m  = (longint'(1) << w);
        ex = (sgn && x >= m/2) ? x - m : x;
        ey = (sgn && y >= m/2) ? y - m : y;
        s  = sub ? ex - ey : ex + ey;
        r  = ((s % m) + m) % m;                 // R10 wrap
        g  = (sgn || sub) ? (s >= 0) : (s >= m);
    endfunction

    function automatic item_t model(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
        item_t it;
        longint r;
        bit g, sgn;
        int kind;
        sgn = !o[3];
        kind = o[2:0];
        it.res = '0; it.g = '0;
        case (kind)
            0, 1, 2, 3: begin
                // upper lane
                lane_ref(16, sgn, (kind == 1 || kind == 3), x[31:16],
                         (kind >= 2) ? y[15:0] : y[31:16], r, g);
                it.res[31:16] = r[15:0]; it.g[3] = g; it.g[2] = g;
                lane_ref(16, sgn, (kind == 1 || kind == 2), x[15:0],
                         (kind >= 2) ? y[31:16] : y[15:0], r, g);
                it.res[15:0] = r[15:0]; it.g[1] = g; it.g[0] = g;
                it.tag = (kind >= 2) ? (sgn ? "R8" : "R9") :
                         (sgn ? "R5" : (kind == 0 ? "R6" : "R7"));
            end
            4, 5: begin
                for (int k = 0; k < 4; k++) begin
                    lane_ref(8, sgn, kind == 5, x[k*8 +: 8], y[k*8 +: 8], r, g);
                    it.res[k*8 +: 8] = r[7:0]; it.g[k] = g;
                end
                it.tag = sgn ? "R4/R5" : (kind == 4 ? "R4/R6" : "R4/R7");
            end
            default: it.tag = "R11";
        endcase
        return it;
    endfunction

    // Driver: apply one beat on a falling edge and push its expected item (R12 codes).
    task automatic drive(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
        @(negedge clk);
        op = o; a = x; b = y; in_valid = 1'b1;
        sb.push_back(model(o, x, y));
    endtask

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Monitor: on each falling edge, pop one item per valid beat and compare (R1).
    always @(negedge clk) begin
        if (rst_n && !done && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R1 unexpected out_valid", 32'h1, 32'h0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(result == it.res, {it.tag, " result (R10)"}, result, it.res);
                check(ge == it.g, {it.tag, " ge (R3)"}, {28'h0, ge}, {28'h0, it.g});
            end
        end
    end

    logic [31:0] pats [12];

    initial begin
        pats[0] = 32'h0000_0000; pats[1] = 32'h7FFF_8000; pats[2] = 32'hFFFF_FFFF;
        pats[3] = 32'h8000_7FFF; pats[4] = 32'h0001_FFFF; pats[5] = 32'h7F80_FF00;
        pats[6] = 32'hFF7F_8001; pats[7] = 32'h8080_7F7F; pats[8] = 32'h1234_ABCD;
        pats[9] = 32'h00FF_0100; pats[10] = 32'hFFFF_0001; pats[11] = 32'h0180_FF7F;

        repeat (3) @(negedge clk);
        // R2: outputs cleared while reset is held
        check(out_valid == 1'b0, "R2 out_valid in reset", {31'h0, out_valid}, 32'h0);
        check(result == 32'h0, "R2 result in reset", result, 32'h0);
        check(ge == 4'h0, "R2 ge in reset", {28'h0, ge}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 idle out_valid", {31'h0, out_valid}, 32'h0);

        for (int o = 0; o < 16; o++)
            for (int i = 0; i < 12; i++)
                for (int j = 0; j < 12; j += 3)
                    drive(o[3:0], pats[i], pats[(i + j) % 12]);

        // R7 equal operands with unsigned byte subtract; R6 carry in every byte
        drive(4'hD, 32'hA5A5_A5A5, 32'hA5A5_A5A5);
        drive(4'hC, 32'h80FF_0180, 32'h8001_FF80);
        // R1: a gap in in_valid, then one more beat
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after gap", {31'h0, out_valid}, 32'h0);
        drive(4'h7, 32'hFFFF_FFFF, 32'h1);   // R11 unused code
        @(negedge clk); in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R1 items left in scoreboard", sb.size(), 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog R1 actual=%h expected=%h", 32'h0, 32'h1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule